// File: doc/BRIEF.md
# Cache Event Counter Bank

This block holds four 64-bit event counters for a cache controller. Each counter has its own configuration word. That word holds an event-select code and a clear-on-read enable. On every clock edge a counter adds one when the strobe chosen by its code is high in the event vector. The cache drives that vector from outside the block.

Code 0 makes a counter count every clock. Codes past the last wired event count nothing.

Software reaches the bank through a plain register port. It can write a counter's value to preset it. It can write a configuration word without disturbing the count. It can read either kind of register. A read returns its data one cycle after the request. When clear-on-read is set for a counter, a read of that counter also empties it.

Top module: `cache_evt_ctr_bank`

## Requirements
- R1: After reset every counter holds 0, and every configuration word reads 0 (select 0, clear-on-read off). `reg_rd_valid` and `reg_rdata` are 0 while reset is held.
- R2: A counter whose select code is 0 adds one on every clock edge, whatever the event vector holds. Bit 0 of `evt_strobe` is never used.
- R3: A counter whose select code k is in 1..53 adds one on each clock edge where `evt_strobe[k]` is 1, and only on those edges.
- R4: A counter whose select code is 54 or higher (up to 255) never counts, even with every strobe high.
- R5: A read request at a clock edge gives `reg_rd_valid` = 1 after that edge, and `reg_rd_valid` = 0 after an edge with no request. `reg_rdata` then holds the register's value from just before that edge.
- R6: With clear-on-read set (config bit 8), a counter read returns the old value and leaves the counter at 0. If the counter's event also fires on that edge, it leaves the counter at 1.
- R7: With clear-on-read off, reading a counter does not change it.
- R8: A configuration write keeps the counter's value. On the edge of the write, the counter still counts under its old select code.
- R9: A write to a counter address loads `reg_wdata` into the counter. The write wins over an increment and over a clear on the same edge.
- R10: A counter holding all ones wraps to 0 on its next increment.
- R11: Address map: `reg_addr[2]`=0 selects counter `reg_addr[1:0]`, and `reg_addr[2]`=1 selects that counter's configuration word. In the configuration word, bits [7:0] are the select code and bit 8 is clear-on-read. A configuration read returns 0 in bits [63:9], and a configuration write ignores those bits.
- R12: Register accesses and events aimed at one counter never change another counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_strobe | input | 54 | Event strobes, bit k for select code k |
| reg_wr_en | input | 1 | Register write request |
| reg_rd_en | input | 1 | Register read request |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid with reg_rd_valid |
| reg_rd_valid | output | 1 | Read data valid, one cycle after the request |

## Verification
Two things can land on the same counter on the same edge: a clear-on-read and the counter's own increment. The bench provokes this with select code 0, so the increment is certain. It then issues two back-to-back reads. The first read must return the running count, and the second must return exactly 1.

A software preset can also collide with an increment. The bench checks this by reading right after a preset on an every-cycle counter. The read must return the written value unchanged.

// File: rtl/cache_evt_ctr_pkg.sv
package cache_evt_ctr_pkg;
  localparam int SEL_W   = 8;
  localparam int CODES   = 1 << SEL_W;

  typedef struct packed {
    logic             clr_rd;
    logic [SEL_W-1:0] code;
  } ctr_cfg_t;

  localparam int CFG_W = $bits(ctr_cfg_t);
endpackage

// File: rtl/cache_evt_sel.sv
module cache_evt_sel
  import cache_evt_ctr_pkg::*;
#(
  parameter int NUM_EVENTS = 54
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_EVENTS-1:0] strobes,
  input  logic [SEL_W-1:0]      code,
  output logic                  hit
);
  logic [CODES-1:0] padded;

  always_comb begin
    padded = '0;
    padded[NUM_EVENTS-1:1] = strobes[NUM_EVENTS-1:1];
    padded[0] = 1'b1;
    hit = padded[code];
  end

  // R4
  high_code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(code) >= NUM_EVENTS) |-> !hit);

  // R2
  cycle_code_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code == '0) |-> hit);
endmodule

// File: rtl/cache_evt_slot.sv
module cache_evt_slot
  import cache_evt_ctr_pkg::*;
#(
  parameter int CNT_W      = 64,
  parameter int NUM_EVENTS = 54
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_EVENTS-1:0] strobes,
  input  logic                  cfg_wr,
  input  ctr_cfg_t              cfg_wdata,
  input  logic                  cnt_wr,
  input  logic [CNT_W-1:0]      cnt_wdata,
  input  logic                  rd_clr,
  output ctr_cfg_t              cfg_q,
  output logic [CNT_W-1:0]      cnt_q
);
  logic hit;

  cache_evt_sel #(.NUM_EVENTS(NUM_EVENTS)) u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobes(strobes),
    .code   (cfg_q.code),
    .hit    (hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt_q <= '0;
    end else begin
      if (cfg_wr) cfg_q <= cfg_wdata;
      if (cnt_wr)      cnt_q <= cnt_wdata;
      else if (rd_clr) cnt_q <= {{(CNT_W-1){1'b0}}, hit};
      else if (hit)    cnt_q <= cnt_q + 1'b1;
    end
  end

  // R9
  preset_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt_q == $past(cnt_wdata));

  // R6
  clear_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !cnt_wr) |=> cnt_q == CNT_W'($past(hit)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && !rd_clr && !hit) |=> $stable(cnt_q));

  // R10
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && !rd_clr && hit && (&cnt_q)) |=> cnt_q == '0);
endmodule

// File: rtl/cache_evt_rdmux.sv
module cache_evt_rdmux
  import cache_evt_ctr_pkg::*;
#(
  parameter int NUM_CTRS = 4,
  parameter int CNT_W    = 64,
  localparam int IDX_W   = $clog2(NUM_CTRS)
) (
  input  logic [IDX_W:0]                  addr,
  input  logic [NUM_CTRS-1:0][CNT_W-1:0]  cnts,
  input  ctr_cfg_t [NUM_CTRS-1:0]         cfgs,
  output logic [CNT_W-1:0]                data
);
  logic [IDX_W-1:0] idx;

  always_comb begin
    idx  = addr[IDX_W-1:0];
    data = '0;
    if (32'(idx) < NUM_CTRS) begin
      if (addr[IDX_W]) data = CNT_W'(cfgs[idx]);
      else             data = cnts[idx];
    end
  end
endmodule

// File: rtl/cache_evt_ctr_bank.sv
module cache_evt_ctr_bank
  import cache_evt_ctr_pkg::*;
#(
  parameter int NUM_CTRS   = 4,
  parameter int CNT_W      = 64,
  parameter int NUM_EVENTS = 54,
  localparam int IDX_W     = $clog2(NUM_CTRS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_EVENTS-1:0] evt_strobe,
  input  logic                  reg_wr_en,
  input  logic                  reg_rd_en,
  input  logic [IDX_W:0]        reg_addr,
  input  logic [CNT_W-1:0]      reg_wdata,
  output logic [CNT_W-1:0]      reg_rdata,
  output logic                  reg_rd_valid
);
  logic [NUM_CTRS-1:0][CNT_W-1:0] cnts;
  ctr_cfg_t [NUM_CTRS-1:0]        cfgs;
  logic [NUM_CTRS-1:0]            cfg_wr, cnt_wr, rd_clr;
  logic [CNT_W-1:0]               mux_data;
  logic [IDX_W-1:0]               idx;
  logic                           is_cfg;

  assign idx    = reg_addr[IDX_W-1:0];
  assign is_cfg = reg_addr[IDX_W];

  for (genvar g = 0; g < NUM_CTRS; g++) begin : g_slot
    logic sel_me;
    assign sel_me    = (32'(idx) == g);
    assign cfg_wr[g] = reg_wr_en && is_cfg && sel_me;
    assign cnt_wr[g] = reg_wr_en && !is_cfg && sel_me;
    assign rd_clr[g] = reg_rd_en && !is_cfg && sel_me && cfgs[g].clr_rd;

    cache_evt_slot #(.CNT_W(CNT_W), .NUM_EVENTS(NUM_EVENTS)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobes  (evt_strobe),
      .cfg_wr   (cfg_wr[g]),
      .cfg_wdata(ctr_cfg_t'(reg_wdata[CFG_W-1:0])),
      .cnt_wr   (cnt_wr[g]),
      .cnt_wdata(reg_wdata),
      .rd_clr   (rd_clr[g]),
      .cfg_q    (cfgs[g]),
      .cnt_q    (cnts[g])
    );
  end

  cache_evt_rdmux #(.NUM_CTRS(NUM_CTRS), .CNT_W(CNT_W)) u_rdmux (
    .addr(reg_addr),
    .cnts(cnts),
    .cfgs(cfgs),
    .data(mux_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata    <= '0;
      reg_rd_valid <= 1'b0;
    end else begin
      reg_rd_valid <= reg_rd_en;
      if (reg_rd_en) reg_rdata <= mux_data;
    end
  end

  // R5
  rd_valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> reg_rd_valid);

  // R5
  rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> !reg_rd_valid);

  // R12
  single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cnt_wr | cfg_wr | rd_clr));
endmodule

// File: tb/cache_evt_ctr_bank_tb.sv
module cache_evt_ctr_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NEV = 54;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NEV-1:0] evt_strobe;
  logic           reg_wr_en, reg_rd_en;
  logic [2:0]     reg_addr;
  logic [63:0]    reg_wdata;
  logic [63:0]    reg_rdata;
  logic           reg_rd_valid;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_evt_ctr_bank u_dut (
    .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rd_valid(reg_rd_valid)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // All tasks enter and leave just after a falling edge.
  task automatic wr(logic [2:0] a, logic [63:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [63:0] d);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    check("R5 rd_valid", 64'(reg_rd_valid), 64'd1);
    d = reg_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [63:0] d;
    rst_n = 1'b0;
    idle(3);
    check("R1 rd_valid in reset", 64'(reg_rd_valid), 64'd0);
    check("R1 rdata in reset", reg_rdata, 64'd0);
    rst_n = 1'b1;
    rd(3'd0, d); check("R1 counter0 reset", d, 64'd0);
    idle(1);
    check("R5 valid drops", 64'(reg_rd_valid), 64'd0);
    for (int i = 4; i < 8; i++) begin
      rd(3'(i), d); check("R1 config reset", d, 64'd0);
    end
  endtask

  task automatic t_cycle_and_clear();
    logic [63:0] d;
    evt_strobe = '0;
    wr(3'd4, 64'h100);
    wr(3'd0, 64'd0);
    idle(5);
    rd(3'd0, d); check("R2 cycle count", d, 64'd5);
    rd(3'd0, d); check("R6 clear with increment", d, 64'd1);
    rd(3'd0, d); check("R6 clear again", d, 64'd1);
  endtask

  task automatic t_event(logic [2:0] c, logic [7:0] code, int seed);
    logic [63:0] d;
    int exp = 0;
    int s = seed;
    wr(3'd4 + c, 64'(code));
    wr(c, 64'd0);
    for (int i = 0; i < 16; i++) begin
      s = (s * 1103515245 + 12345) & 32'h7fffffff;
      evt_strobe = {NEV{1'b0}};
      evt_strobe[0] = 1'b1;
      evt_strobe[code] = s[9];
      evt_strobe[(code % 40) + 1] = s[3] | (code == 8'd5 ? 1'b0 : 1'b1);
      if (evt_strobe[code]) exp++;
      @(negedge clk);
    end
    evt_strobe = '0;
    rd(c, d); check("R3 event count", d, 64'(exp));
  endtask

  task automatic t_high_codes();
    logic [63:0] d;
    wr(3'd6, 64'd54);
    wr(3'd2, 64'd0);
    evt_strobe = '1;
    idle(10);
    rd(3'd2, d); check("R4 code 54", d, 64'd0);
    wr(3'd6, 64'd255);
    idle(10);
    evt_strobe = '0;
    rd(3'd2, d); check("R4 code 255", d, 64'd0);
  endtask

  task automatic t_no_clear_then_clear();
    logic [63:0] d;
    wr(3'd7, 64'd60);
    wr(3'd3, 64'd42);
    rd(3'd3, d); check("R7 first read", d, 64'd42);
    rd(3'd3, d); check("R7 value kept", d, 64'd42);
    wr(3'd7, 64'h13C);
    rd(3'd7, d); check("R11 config readback", d, 64'h13C);
    rd(3'd3, d); check("R6 read old value", d, 64'd42);
    rd(3'd3, d); check("R6 cleared", d, 64'd0);
  endtask

  task automatic t_cfg_keeps_count();
    logic [63:0] d;
    wr(3'd6, 64'd0);
    wr(3'd2, 64'd100);
    idle(3);
    wr(3'd6, 64'hFFFF_0000_0000_0007);
    rd(3'd2, d); check("R8 count kept", d, 64'd104);
    rd(3'd6, d); check("R11 upper bits ignored", d, 64'd7);
  endtask

  task automatic t_preset_and_wrap();
    logic [63:0] d;
    wr(3'd4, 64'd0);
    wr(3'd0, 64'd500);
    rd(3'd0, d); check("R9 preset wins", d, 64'd500);
    wr(3'd0, '1);
    rd(3'd0, d); check("R10 all ones", d, '1);
    rd(3'd0, d); check("R10 wrapped", d, 64'd0);
  endtask

  task automatic t_independence();
    logic [63:0] d;
    wr(3'd7, 64'd60);
    wr(3'd3, 64'd7);
    wr(3'd1, 64'd999);
    wr(3'd5, 64'h13C);
    rd(3'd1, d);
    evt_strobe = '1;
    idle(4);
    evt_strobe = '0;
    rd(3'd3, d); check("R12 neighbour untouched", d, 64'd7);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; evt_strobe = '0;
    reg_wr_en = 1'b0; reg_rd_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    @(negedge clk);
    t_reset();
    t_cycle_and_clear();
    t_event(3'd1, 8'd5, 7);
    t_event(3'd1, 8'd53, 91);
    t_high_codes();
    t_no_clear_then_clear();
    t_cfg_keeps_count();
    t_preset_and_wrap();
    t_independence();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule